// File: doc/BRIEF.md
# Cubic spline DC-bias generator

This block produces one signed 16-bit DAC code per clock at 125 MS/s. Each code is a sample of a cubic polynomial in time. The polynomial is not evaluated directly. Four 48-bit forward-difference accumulators are chained so that each one adds its neighbour every cycle. No multipliers are needed because the incoming higher-order coefficients already carry the Taylor factors 2 and 6. The code spans -10 V to just under +10 V, so one LSB is 20 V / 65536.

The four coefficients are staged as nine 16-bit words through a write port that carries a word index and data. They sit in shadow registers and do nothing until this channel's bit in a shared trigger mask is pulsed. The pulse copies the whole staged set into the accumulators in one cycle and restarts the polynomial at time zero. A channel whose bit stays low keeps running its previous waveform. Each coefficient is aligned to a common 48-bit fixed-point format in which the output code occupies the top 16 bits:

- the constant term has no fractional bits;
- the slope has 16 fractional bits;
- the second- and third-order steps have 32 fractional bits.

Top module: `spline_dcbias`

## Requirements
- R1: While reset is low, and after it is released, the output code is 0 and the staged set is all zero. A trigger issued before any write therefore keeps the output at 0.
- R2: Word index 0 is the constant term. Indices 1 and 2 are the low and high halves of the 32-bit slope. Indices 3, 4 and 5 are the low, middle and high words of the 48-bit second-order step. Indices 6, 7 and 8 are the same three words of the 48-bit third-order step.
- R3: A write alters only the staged set. Until the next trigger, the running output continues exactly as if the write had not occurred.
- R4: Only bit TRIG_BIT of the trigger mask loads this channel; every other mask bit has no effect. When a write and a trigger fall in the same cycle, the load uses the staged content from before that write, and the write still lands in the staging registers.
- R5: On the first sample after the trigger edge, the output equals the constant term.
- R6: With only the constant and slope nonzero, sample n after the load equals the top 16 bits of a0·2^32 + n·a1·2^16, so fractional slopes accumulate below the LSB.
- R7: Each cycle the accumulators update from their old values: x0 += x1, x1 += x2, x2 += x3, with x3 held. Sample n therefore includes C(n,2)·a2 for a nonzero second-order step.
- R8: A nonzero third-order step adds C(n,3)·a3 to sample n. Negative steps, written in two's complement across the three words, are handled the same way.
- R9: All accumulation is modulo 2^48. Passing +10 V wraps the output code from 0x7FFF to 0x8000 without saturating.
- R10: Writes with word index 9 to 15 change nothing.
- R11: The staged set persists after a trigger. Triggering again without new writes restarts the same waveform from n = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one output code per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_idx | input | 4 | Coefficient word index, 0 to 8 valid |
| wr_data | input | 16 | Coefficient word |
| trig_mask | input | TRIG_W (16) | Shared trigger mask; bit TRIG_BIT loads this channel |
| sample | output | 16 | Two's-complement DAC code |

## Verification
The bench builds the block with TRIG_BIT set to 5 rather than 0. This shows that the load comes from the selected mask bit and not from bit 0, and a pattern with only the other fifteen bits set can then be shown to be ignored. TRIG_W stays at 16, the full shared mask width. Each predicted sample is computed from the closed-form binomial expansion of the staged words instead of from a running sum. The runs are long enough for the cubic term and the +10 V wrap to dominate the output.

// File: rtl/spline_dcbias_pkg.sv
`timescale 1ns/1ps
package spline_dcbias_pkg;

  // Coefficient word geometry
  localparam int WORD_W   = 16;
  localparam int IDX_W    = 4;
  localparam int A0_WORDS = 1;
  localparam int A1_WORDS = 2;
  localparam int A2_WORDS = 3;
  localparam int A3_WORDS = 3;
  localparam int N_WORDS  = A0_WORDS + A1_WORDS + A2_WORDS + A3_WORDS;

  // Word index bases; the sequence is part of the write protocol
  localparam int BASE_A0 = 0;
  localparam int BASE_A1 = BASE_A0 + A0_WORDS;
  localparam int BASE_A2 = BASE_A1 + A1_WORDS;
  localparam int BASE_A3 = BASE_A2 + A2_WORDS;

  // Common fixed-point accumulator: output code on top, fraction below
  localparam int ACC_W   = A2_WORDS * WORD_W;
  localparam int FRAC_W  = ACC_W - WORD_W;
  localparam int A1_PAD  = ACC_W - A1_WORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ACC_W-1:0]  acc_t;

  typedef struct packed {
    acc_t c3;
    acc_t c2;
    acc_t c1;
    acc_t c0;
  } coef_set_t;

  // Constant term: integer code shifted above the fraction
  function automatic acc_t align_const(input word_t w);
    return {w, {FRAC_W{1'b0}}};
  endfunction

  // Slope: two words, padded below to the common fraction width
  function automatic acc_t align_slope(input word_t hi, input word_t lo);
    return {hi, lo, {A1_PAD{1'b0}}};
  endfunction

  // Higher-order steps: three words already at full width
  function automatic acc_t join_step(input word_t hi, input word_t mid, input word_t lo);
    return {hi, mid, lo};
  endfunction

  // One forward-difference stage, modular
  function automatic acc_t diff_add(input acc_t a, input acc_t b);
    return a + b;
  endfunction

  // DAC code taken from the integer part of the position accumulator
  function automatic word_t dac_code(input acc_t x);
    return x[ACC_W-1 -: WORD_W];
  endfunction

endpackage

// File: rtl/spline_trig_pick.sv
`timescale 1ns/1ps
module spline_trig_pick #(
  parameter int TRIG_W   = 16,
  parameter int TRIG_BIT = 0
) (
  input  logic [TRIG_W-1:0] trig_mask,
  output logic              load_evt
);
  localparam logic [TRIG_W-1:0] SEL = TRIG_W'(1) << TRIG_BIT;

  // Masking keeps every mask bit in the logic cone
  assign load_evt = |(trig_mask & SEL);

endmodule

// File: rtl/spline_shadow.sv
`timescale 1ns/1ps
module spline_shadow
  import spline_dcbias_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_data,
  output coef_set_t        staged,
  output logic             wr_accept
);

  word_t             words_q [N_WORDS];
  logic [N_WORDS-1:0] word_hit;

  // One decoder per staged word
  for (genvar g = 0; g < N_WORDS; g++) begin : g_dec
    assign word_hit[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  assign wr_accept = |word_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WORDS; i++) words_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (word_hit[i]) words_q[i] <= wr_data;
      end
    end
  end

  // Assemble aligned coefficients from the staged words
  always_comb begin
    staged.c0 = align_const(words_q[BASE_A0]);
    staged.c1 = align_slope(words_q[BASE_A1+1], words_q[BASE_A1]);
    staged.c2 = join_step(words_q[BASE_A2+2], words_q[BASE_A2+1], words_q[BASE_A2]);
    staged.c3 = join_step(words_q[BASE_A3+2], words_q[BASE_A3+1], words_q[BASE_A3]);
  end

endmodule

// File: rtl/spline_cascade.sv
`timescale 1ns/1ps
module spline_cascade
  import spline_dcbias_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  coef_set_t seed,
  output acc_t      x0,
  output acc_t      x1,
  output acc_t      x2,
  output acc_t      x3
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0 <= '0;
      x1 <= '0;
      x2 <= '0;
      x3 <= '0;
    end else if (load) begin
      x0 <= seed.c0;
      x1 <= seed.c1;
      x2 <= seed.c2;
      x3 <= seed.c3;
    end else begin
      // Every stage sees its neighbour's pre-edge value
      x0 <= diff_add(x0, x1);
      x1 <= diff_add(x1, x2);
      x2 <= diff_add(x2, x3);
    end
  end

endmodule

// File: rtl/spline_dcbias.sv
`timescale 1ns/1ps
module spline_dcbias
  import spline_dcbias_pkg::*;
#(
  parameter int TRIG_W   = 16,
  parameter int TRIG_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [15:0]       wr_data,
  input  logic [TRIG_W-1:0] trig_mask,
  output logic [15:0]       sample
);

  logic      load_evt;
  logic      wr_accept;
  coef_set_t seed_set;
  acc_t      x0_q, x1_q, x2_q, x3_q;

  spline_trig_pick #(.TRIG_W(TRIG_W), .TRIG_BIT(TRIG_BIT)) u_pick (
    .trig_mask (trig_mask),
    .load_evt  (load_evt)
  );

  spline_shadow u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .staged    (seed_set),
    .wr_accept (wr_accept)
  );

  spline_cascade u_cascade (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .seed  (seed_set),
    .x0    (x0_q),
    .x1    (x1_q),
    .x2    (x2_q),
    .x3    (x3_q)
  );

  assign sample = dac_code(x0_q);

endmodule

// File: rtl/spline_dcbias_chk.sv
`timescale 1ns/1ps
module spline_dcbias_chk
  import spline_dcbias_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      load_evt,
  input logic      wr_accept,
  input coef_set_t seed,
  input acc_t      x0,
  input acc_t      x1,
  input acc_t      x2,
  input acc_t      x3,
  input word_t     sample
);

  // R1
  rst_clear_chk: assert property (@(posedge clk) !rst_n |=> (sample == '0));

  // R5
  load_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (x0 == $past(seed.c0)) && (x1 == $past(seed.c1)) &&
                 (x2 == $past(seed.c2)) && (x3 == $past(seed.c3)));

  // R7
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> (x0 == $past(x0) + $past(x1)) && (x1 == $past(x1) + $past(x2)));

  // R8
  cubic_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> (x2 == $past(x2) + $past(x3)) && $stable(x3));

  // R10
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> $stable(seed));

endmodule

bind spline_dcbias spline_dcbias_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_evt  (load_evt),
  .wr_accept (wr_accept),
  .seed      (seed_set),
  .x0        (x0_q),
  .x1        (x1_q),
  .x2        (x2_q),
  .x3        (x3_q),
  .sample    (sample)
);

// File: tb/spline_dcbias_test.sv
`timescale 1ns/1ps
module spline_dcbias_test;

  localparam int TW  = 16;
  localparam int TB  = 5;
  localparam logic [TW-1:0] OWN    = TW'(1) << TB;
  localparam logic [TW-1:0] OTHERS = ~OWN;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_idx = '0;
  logic [15:0]   wr_data = '0;
  logic [TW-1:0] trig_mask = '0;
  logic [15:0]   sample;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  spline_dcbias #(.TRIG_W(TW), .TRIG_BIT(TB)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .trig_mask(trig_mask), .sample(sample)
  );

  always #2.5 clk = ~clk;

  // Bench-side model: staged words, active words, samples since load
  logic [15:0] st_w  [9];
  logic [15:0] act_w [9];
  longint unsigned n_since;

  logic [15:0] exp_q [$];
  string       req_q [$];

  function automatic logic [15:0] predict(input longint unsigned n);
    longint unsigned a0, a1, a2, a3, c2, c3, v;
    a0 = {16'h0, act_w[0], 32'h0};
    a1 = {16'h0, act_w[2], act_w[1], 16'h0};
    a2 = {16'h0, act_w[5], act_w[4], act_w[3]};
    a3 = {16'h0, act_w[8], act_w[7], act_w[6]};
    c2 = (n * (n - 1)) / 2;
    c3 = (n < 2) ? 0 : (n * (n - 1) * (n - 2)) / 6;
    v  = a0 + n * a1 + c2 * a2 + c3 * a3;
    return v[47:32];
  endfunction

  // One clock: update the model at the edge, queue the prediction
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) begin st_w[i] = '0; act_w[i] = '0; end
      n_since = 0;
    end else begin
      if ((trig_mask & OWN) != '0) begin
        for (int i = 0; i < 9; i++) act_w[i] = st_w[i];
        n_since = 0;
      end else begin
        n_since++;
      end
      if (wr_en && wr_idx < 9) st_w[wr_idx] = wr_data;
    end
    exp_q.push_back(predict(n_since));
    req_q.push_back(cur_req);
    @(negedge clk);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic put(input logic [3:0] idx, input logic [15:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic fire(input logic [TW-1:0] m);
    trig_mask = m;
    step();
    trig_mask = '0;
  endtask

  task automatic load_set(input logic [15:0] w [9]);
    for (int i = 0; i < 9; i++) put(4'(i), w[i]);
  endtask

  // Monitor: compare each queued prediction half a cycle later
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (sample !== e) begin
        fails++;
        $display("FAIL %s: sample=%h expected=%h", r, sample, e);
      end
    end
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] w [9];
    #1;
    checks++;
    if (sample !== 16'h0) begin
      fails++;
      $display("FAIL R1: sample=%h expected=0000", sample);
    end
    idle(3);
    rst_n = 1'b1;
    // R1: trigger with nothing staged stays at zero
    idle(3);
    fire(OWN);
    idle(5);

    // R3: staged constant invisible until triggered
    cur_req = "R3";
    put(4'd0, 16'h1234);
    idle(4);
    // R5: first sample after trigger equals the constant
    cur_req = "R5";
    fire(OWN);
    idle(4);

    // R4: foreign bits ignored, own bit loads
    cur_req = "R4";
    put(4'd0, 16'h4444);
    fire(OTHERS);
    idle(4);
    fire(OWN);
    idle(3);

    // R6: fractional slope of 2.5 LSB per sample
    cur_req = "R6";
    w = '{16'h0100, 16'h8000, 16'h0002, 0, 0, 0, 0, 0, 0};
    load_set(w);
    fire(OWN);
    idle(20);

    // R3 and R11: writes and foreign triggers during a running ramp
    cur_req = "R11";
    put(4'd0, 16'h7000);
    put(4'd2, 16'h0000);
    fire(OTHERS);
    idle(10);

    // R7: quadratic, one LSB second difference from a negative start
    cur_req = "R7";
    w = '{16'hF000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 0, 0, 0};
    load_set(w);
    fire(OWN);
    idle(40);

    // R8: cubic half-LSB third step against a negative second step
    cur_req = "R8";
    w = '{16'h0020, 16'h0000, 16'h0004, 16'h0000, 16'h0000, 16'hFFFF,
          16'h0000, 16'h8000, 16'h0000};
    load_set(w);
    fire(OWN);
    idle(60);

    // R9: wrap through +10 V
    cur_req = "R9";
    w = '{16'h7FF0, 16'h0000, 16'h0003, 0, 0, 0, 0, 0, 0};
    load_set(w);
    fire(OWN);
    idle(12);

    // R10: out-of-range indices, then R11 retrigger replays the same set
    cur_req = "R10";
    for (int i = 9; i < 16; i++) put(4'(i), 16'hDEAD);
    fire(OWN);
    idle(12);

    // R2: every word distinct and visible
    cur_req = "R2";
    w = '{16'h0010, 16'h1234, 16'h0001, 16'h5000, 16'h2000, 16'h0000,
          16'h0003, 16'h4000, 16'h0000};
    load_set(w);
    fire(OWN);
    idle(30);

    // R4: write and trigger in the same cycle, load uses prior staging
    cur_req = "R4";
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 16'h0555; trig_mask = OWN;
    step();
    wr_en = 1'b0; trig_mask = '0;
    idle(4);
    fire(OWN);
    idle(4);

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule